// File: doc/BRIEF.md
# Modulo Feedback Precoder for One PAM Lane

The block pre-distorts a stream of odd-integer PAM symbols so that a channel with a known causal response cancels the distortion at the receiver. Each accepted symbol has a feedback term subtracted from it. That term is a weighted sum of the block's own most recent outputs. The difference is then folded into a fixed amplitude window by adding whatever integer multiple of 2M brings it into range. Because of the fold, the transmitted amplitude stays bounded, and the receiver recovers the symbol with a plain modulo operation.

The channel model is taken as a leading tap of exactly one, followed by programmable trailing taps. Only the trailing taps are stored and fed back. Software loads them through a small write port before traffic starts. A synchronous clear input empties the feedback history without resetting the coefficients. Each accepted symbol produces one output sample one cycle later, marked by an output strobe.

Top module: `thp_precoder`

## Requirements
- R1: After the asynchronous reset, `out_valid_o` is 0, `out_o` is 0, all coefficients are 0 and the history is 0. The first symbol after reset therefore leaves as exactly `sym_i * 256`.
- R2: `out_valid_o` is 1 in the cycle after a cycle in which `sym_valid_i` was 1 and `hist_clr_i` was 0. In every other cycle it is 0.
- R3: Every emitted sample, read as a signed two's-complement value with 8 fraction bits, lies in [-M, M) with M = 16. In raw units that is [-4096, 4096).
- R4: An emitted sample equals `sym_i*256 - floor(F/1024)` plus an integer multiple of 2M·256 = 8192. F is the sum over taps of the signed coefficient times the signed history sample. Coefficients are signed with 10 fraction bits. Samples are signed with 8 fraction bits.
- R5: Tap index j (0-based) weights the output emitted j+1 accepted symbols earlier. Cycles without an accepted symbol do not move the history.
- R6: A coefficient write (`coef_we_i` = 1) stores `coef_data_i` into tap `coef_idx_i` only when `sym_valid_i` is 0. When `sym_valid_i` is 1 in the same cycle, the write has no effect.
- R7: `hist_clr_i` = 1 zeroes the whole history and takes priority over `sym_valid_i`. The symbol in that cycle is discarded and no output strobe follows it.
- R8: When no symbol is accepted, `out_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hist_clr_i | input | 1 | Synchronous clear of the feedback history |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | SYM_W (5) | Signed odd symbol, ±1 to ±15 |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_idx_i | input | IDX_W (2) | Tap index, 0 = first delayed tap |
| coef_data_i | input | COEF_W (12) | Signed coefficient, 10 fraction bits |
| out_valid_o | output | 1 | Output strobe |
| out_o | output | OUT_W (13) | Signed precoded sample, 8 fraction bits |

## Verification
A wrong history entry or coefficient only shows at the ports on a later accepted symbol, once its tap is non-zero. A defect in tap j therefore becomes visible up to j+1 accepted symbols after it occurs. The stimulus mixes strong random coefficients with dense symbol bursts so that such a defect reaches the output within a few samples. Idle gaps, clears and blocked writes are each followed by more symbols. The state they must leave untouched, or must zero, is then seen through the next outputs.

// File: rtl/thp_pkg.sv
package thp_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_CLEAR, OP_PUSH} op_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/thp_coef_bank.sv
module thp_coef_bank #(
  parameter int NTAPS  = 4,
  parameter int COEF_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic signed [COEF_W-1:0] data_i,
  output logic signed [COEF_W-1:0] coef_o [NTAPS]
);
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              coef_o[g] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))    coef_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/thp_history.sv
module thp_history #(
  parameter int NTAPS = 4,
  parameter int OUT_W = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    shift_i,
  input  logic signed [OUT_W-1:0] din_i,
  output logic signed [OUT_W-1:0] hist_o [NTAPS]
);
  for (genvar g = 0; g < NTAPS; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_o[g] <= '0;
      else if (clr_i)   hist_o[g] <= '0;
      else if (shift_i) hist_o[g] <= (g == 0) ? din_i : hist_o[(g == 0) ? 0 : g-1];
    end
  end

  // newest sample lands in stage 0 only on an accepted symbol
  assert_shift_in_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i) |=> (hist_o[0] == $past(din_i)));
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clr_i) |=> $stable(hist_o[0]));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (hist_o[NTAPS-1] == '0 && hist_o[0] == '0));
endmodule

// File: rtl/thp_fir.sv
module thp_fir #(
  parameter int NTAPS     = 4,
  parameter int COEF_W    = 12,
  parameter int COEF_FRAC = 10,
  parameter int OUT_W     = 13
) (
  input  logic signed [COEF_W-1:0] coef_i [NTAPS],
  input  logic signed [OUT_W-1:0]  hist_i [NTAPS],
  output logic signed [OUT_W-1:0]  fb_o
);
  // bits above the output window are removed by the fold, so never form them
  localparam int WRAP_W = OUT_W + COEF_FRAC;

  logic [WRAP_W-1:0] prod [NTAPS];
  logic [WRAP_W-1:0] acc;
  logic              unused_frac;

  for (genvar g = 0; g < NTAPS; g++) begin : g_mul
    assign prod[g] = WRAP_W'(coef_i[g]) * WRAP_W'(hist_i[g]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++) acc = acc + prod[i];
  end

  assign fb_o        = acc[WRAP_W-1:COEF_FRAC];
  assign unused_frac = ^acc[COEF_FRAC-1:0];
endmodule

// File: rtl/thp_precoder.sv
module thp_precoder
  import thp_pkg::*;
#(
  parameter int SYM_W     = 5,
  parameter int NTAPS     = 4,
  parameter int COEF_W    = 12,
  parameter int COEF_FRAC = 10,
  parameter int OUT_INT   = 5,
  parameter int OUT_FRAC  = 8,
  localparam int OUT_W    = OUT_INT + OUT_FRAC,
  localparam int IDX_W    = idx_bits(NTAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hist_clr_i,
  input  logic                     sym_valid_i,
  input  logic signed [SYM_W-1:0]  sym_i,
  input  logic                     coef_we_i,
  input  logic [IDX_W-1:0]         coef_idx_i,
  input  logic signed [COEF_W-1:0] coef_data_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  out_o
);
  // window is [-2^(OUT_INT-1), 2^(OUT_INT-1)); folding by 2M is dropping bits above OUT_W
  initial begin
    if (SYM_W > OUT_INT) $error("symbol wider than output integer part");
  end

  op_e                     op;
  logic                    coef_wr;
  logic signed [COEF_W-1:0] coef [NTAPS];
  logic signed [OUT_W-1:0]  hist [NTAPS];
  logic signed [OUT_W-1:0]  fb;
  logic signed [OUT_W-1:0]  sym_q;
  logic signed [OUT_W-1:0]  next_x;

  always_comb begin
    if (hist_clr_i)       op = OP_CLEAR;
    else if (sym_valid_i) op = OP_PUSH;
    else                  op = OP_IDLE;
  end

  assign coef_wr = coef_we_i && !sym_valid_i;

  thp_coef_bank #(.NTAPS(NTAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_coef (
    .clk_i, .rst_ni,
    .we_i   (coef_wr),
    .idx_i  (coef_idx_i),
    .data_i (coef_data_i),
    .coef_o (coef)
  );

  thp_history #(.NTAPS(NTAPS), .OUT_W(OUT_W)) u_hist (
    .clk_i, .rst_ni,
    .clr_i   (op == OP_CLEAR),
    .shift_i (op == OP_PUSH),
    .din_i   (next_x),
    .hist_o  (hist)
  );

  thp_fir #(.NTAPS(NTAPS), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .OUT_W(OUT_W)) u_fir (
    .coef_i (coef),
    .hist_i (hist),
    .fb_o   (fb)
  );

  assign sym_q  = OUT_W'(sym_i) <<< OUT_FRAC;
  assign next_x = sym_q - fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_o       <= '0;
    end else begin
      out_valid_o <= (op == OP_PUSH);
      if (op == OP_PUSH) out_o <= next_x;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && !hist_clr_i) |=> out_valid_o);
  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sym_valid_i && !hist_clr_i) |=> !out_valid_o);
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_o == $past(out_o)) || $rose(rst_ni) || $fell(out_valid_o));

  for (genvar g = 0; g < NTAPS; g++) begin : g_lock
    assert_coef_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sym_valid_i |=> $stable(coef[g]));
  end
endmodule

// File: tb/thp_precoder_test.sv
module thp_precoder_test;
  localparam int NTAPS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hist_clr_i = 1'b0;
  logic sym_valid_i = 1'b0;
  logic signed [4:0] sym_i = '0;
  logic coef_we_i = 1'b0;
  logic [1:0] coef_idx_i = '0;
  logic signed [11:0] coef_data_i = '0;
  logic out_valid_o;
  logic signed [12:0] out_o;

  always #2.5 clk = ~clk;

  thp_precoder uut (
    .clk_i(clk), .rst_ni, .hist_clr_i, .sym_valid_i, .sym_i,
    .coef_we_i, .coef_idx_i, .coef_data_i, .out_valid_o, .out_o
  );

  int n_chk = 0, n_bad = 0;
  int m_coef [NTAPS];
  int m_hist [NTAPS];
  int m_out = 0;
  bit m_valid = 0;

  function automatic int fold(input int v);
    int w = v & 8191;
    if (w >= 4096) w -= 8192;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, check after the next rising edge
  task automatic step(input bit v, input int s, input bit clr, input bit we,
                      input int idx, input int data, input string req);
    int fb;
    sym_valid_i = v; sym_i = 5'(s); hist_clr_i = clr;
    coef_we_i = we; coef_idx_i = 2'(idx); coef_data_i = 12'(data);
    if (clr) begin
      foreach (m_hist[i]) m_hist[i] = 0;
      m_valid = 0;
    end else if (v) begin
      fb = 0;
      foreach (m_hist[i]) fb += m_coef[i] * m_hist[i];
      m_out = fold(s * 256 - (fb >>> 10));
      for (int i = NTAPS-1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m_out;
      m_valid = 1;
    end else m_valid = 0;
    if (we && !v) m_coef[idx] = data;
    @(posedge clk);
    @(negedge clk);
    check(out_valid_o == m_valid, {req, " R2 valid"}, int'(out_valid_o), int'(m_valid));
    check(int'(out_o) == m_out, {req, " data"}, int'(out_o), m_out);
    check(int'(out_o) >= -4096 && int'(out_o) < 4096, "R3 range", int'(out_o), 0);
  endtask

  function automatic int rsym();
    return 2 * int'($urandom % 16) - 15;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    foreach (m_coef[i]) begin m_coef[i] = 0; m_hist[i] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R1 reset valid", int'(out_valid_o), 0);
    check(out_o == '0, "R1 reset data", int'(out_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: no feedback with cleared coefficients
    step(1, 15, 0, 0, 0, 0, "R1");
    check(int'(out_o) == 3840, "R1 first symbol", int'(out_o), 3840);
    step(1, -1, 0, 0, 0, 0, "R1");

    // R5/R4: single unit tap h1 = 1.0 folds 15,15 to 0
    step(1, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 1024, "R6");
    step(1, 15, 0, 0, 0, 0, "R4");
    step(1, 15, 0, 0, 0, 0, "R4");
    check(int'(out_o) == 0, "R4 unit tap", int'(out_o), 0);
    step(1, 15, 0, 0, 0, 0, "R4");
    check(int'(out_o) == 3840, "R4 unit tap 2", int'(out_o), 3840);

    // R5: tap 3 only, idle gaps must not shift
    step(0, 0, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 1, 3, -2048, "R6");
    step(1, 0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 6; i++) begin
      step(1, rsym(), 0, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, "R8");
    end

    // R6: writes during valid are dropped
    for (int i = 0; i < 8; i++) step(1, rsym(), 0, 1, i % 4, 2047, "R6 blocked");

    // extreme coefficients
    for (int t = 0; t < 4; t++) step(0, 0, 0, 1, t, (t % 2) ? -2048 : 2047, "R6");
    for (int i = 0; i < 12; i++) step(1, (i % 2) ? -15 : 15, 0, 0, 0, 0, "R4 extreme");

    // R7: clear with valid high discards symbol, next sample has no feedback
    step(1, 7, 1, 0, 0, 0, "R7");
    step(1, -9, 0, 0, 0, 0, "R7");
    check(int'(out_o) == -2304, "R7 after clear", int'(out_o), -2304);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      if (r < 3)       step(($urandom % 2) == 1, rsym(), 1, 0, 0, 0, "R7 rand");
      else if (r < 10) step(0, 0, 0, 1, int'($urandom % 4), int'($urandom % 4096) - 2048, "R6 rand");
      else if (r < 13) step(1, rsym(), 0, 1, int'($urandom % 4), int'($urandom % 4096) - 2048, "R6 rand blocked");
      else if (r < 25) step(0, rsym(), 0, 0, 0, 0, "R8 rand");
      else             step(1, rsym(), 0, 0, 0, 0, "R4 rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule